// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor Core

This block is a small 16-bit processor built around one accumulator. It runs a program held in a word-addressed memory of 4096 entries. Each instruction word has two parts: a 4-bit operation code in bits 15..12 and a 12-bit operand address S in bits 11..0. The datapath has four parts: a program counter, an instruction register, the accumulator and a four-function ALU. Two multiplexers steer it. The first sends either the program counter or the operand field to the memory address bus. The second gives the ALU either the memory read data or the current address as its second operand.

A two-phase controller drives the clock-enables, the multiplexer selects, the ALU function and the memory strobes. It uses two feedback flags from the accumulator: zero and sign. Every instruction takes exactly one clock per memory access it makes. Loads, stores, additions and subtractions spend one cycle on their operand and then fetch the next instruction. Jumps fetch their successor in the same cycle in which they decide where it is. The memory writes on the rising edge when a request is made with the read/not-write line low. Its read data must be valid within the same cycle the address is presented. A stop instruction, or any unassigned code, halts the core until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: Opcode 0x0 in bits 15..12 loads the accumulator with the memory word at the address in bits 11..0, and the operand address appears on `mem_addr` in the cycle after the instruction is fetched.
- R2: Opcode 0x2 adds the word at S to the accumulator and opcode 0x3 subtracts it, both modulo 2^16 with no flags kept.
- R3: Opcode 0x1 writes the accumulator to address S with `mem_rnw` low for exactly that one cycle; in every other cycle `mem_wdata` is zero.
- R4: Opcode 0x4 always jumps to S; 0x5 jumps when accumulator bit 15 is 0; 0x6 jumps when the accumulator is non-zero; an untaken jump continues at the next address.
- R5: Opcodes 0x0 to 0x3 take two clock cycles and opcodes 0x4 to 0x6 take one, the fetch of the following instruction included.
- R6: While reset is high no memory request is made; in the first cycle after reset the core fetches from address 0, with the accumulator cleared.
- R7: Opcode 0x7 and every opcode 0x8 to 0xF raise `halted`, stop all memory requests and leave the core frozen until reset.
- R8: The program counter wraps from 0xFFF to 0x000.
- R9: `mem_req` is high in every cycle in which the core is neither in reset nor halted.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Accumulator value during a store, zero otherwise |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| mem_req | output | 1 | Memory access request |
| mem_rnw | output | 1 | High for read, low for write |
| halted | output | 1 | Core has reached a stop or unassigned opcode |

## Verification
Counting from the cycle after reset is released as cycle 1, the first fetch addresses word 0 in cycle 1. A memory-operand instruction fetched in cycle k presents its operand address in cycle k+1 and its successor's fetch in cycle k+2. A jump fetched in cycle k presents its target in cycle k+1. `halted` is therefore first visible after exactly as many rising edges as the program's total memory accesses, and the bench counts edges from reset release and compares that count with a total worked out by hand per program. All port values are sampled on the falling edge that follows the edge in question, so each check looks at a cycle whose number has been derived in advance.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned OPC_W  = WORD_W - ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 0,
        OP_STORE = 1,
        OP_ADD   = 2,
        OP_SUB   = 3,
        OP_JUMP  = 4,
        OP_JPOS  = 5,
        OP_JNZ   = 6,
        OP_HALT  = 7
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_PASS_B = 2'd0,
        ALU_INC_B  = 2'd1,
        ALU_ADD    = 2'd2,
        ALU_SUB    = 2'd3
    } alu_fn_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic    addr_sel_op;
        logic    b_sel_addr;
        alu_fn_e alu_fn;
        logic    pc_ce;
        logic    ir_ce;
        logic    acc_ce;
        logic    acc_oe;
        logic    mem_req;
        logic    mem_rnw;
    } ctrl_t;

    function automatic word_t alu_eval(alu_fn_e fn, word_t a, word_t b);
        word_t y;
        case (fn)
            ALU_PASS_B: y = b;
            ALU_INC_B:  y = b + word_t'(1);
            ALU_ADD:    y = a + b;
            default:    y = a - b;
        endcase
        return y;
    endfunction

    function automatic word_t zext_addr(addr_t a);
        return {{(WORD_W-ADDR_W){1'b0}}, a};
    endfunction

endpackage

// File: rtl/acc_en_reg.sv
module acc_en_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opc_t  opcode,
    input  logic  acc_zero,
    input  logic  acc_neg,
    output ctrl_t ctl,
    output logic  halted
);

    phase_e phase_q;
    phase_e phase_d;
    logic   is_jump;
    logic   take;

    always_comb begin
        ctl         = '0;
        ctl.mem_rnw = 1'b1;
        ctl.alu_fn  = ALU_PASS_B;
        phase_d     = phase_q;
        halted      = 1'b0;
        is_jump     = 1'b0;
        take        = 1'b0;

        if (!rst) begin
            if (phase_q == PH_FETCH) begin
                // Fetch at PC, PC <= PC + 1 through the ALU.
                ctl.b_sel_addr = 1'b1;
                ctl.alu_fn     = ALU_INC_B;
                ctl.pc_ce      = 1'b1;
                ctl.ir_ce      = 1'b1;
                ctl.mem_req    = 1'b1;
                phase_d        = PH_EXEC;
            end else begin
                case (opcode_e'(opcode))
                    OP_LOAD, OP_ADD, OP_SUB: begin
                        ctl.addr_sel_op = 1'b1;
                        ctl.acc_ce      = 1'b1;
                        ctl.mem_req     = 1'b1;
                        ctl.alu_fn      = (opcode_e'(opcode) == OP_ADD) ? ALU_ADD :
                                          (opcode_e'(opcode) == OP_SUB) ? ALU_SUB :
                                                                          ALU_PASS_B;
                        phase_d         = PH_FETCH;
                    end
                    OP_STORE: begin
                        ctl.addr_sel_op = 1'b1;
                        ctl.acc_oe      = 1'b1;
                        ctl.mem_req     = 1'b1;
                        ctl.mem_rnw     = 1'b0;
                        phase_d         = PH_FETCH;
                    end
                    OP_JUMP: begin
                        is_jump = 1'b1;
                        take    = 1'b1;
                    end
                    OP_JPOS: begin
                        is_jump = 1'b1;
                        take    = !acc_neg;
                    end
                    OP_JNZ: begin
                        is_jump = 1'b1;
                        take    = !acc_zero;
                    end
                    default: begin
                        halted = 1'b1;
                    end
                endcase

                if (is_jump) begin
                    // Fetch the successor now: from S if taken, else from PC.
                    ctl.addr_sel_op = take;
                    ctl.b_sel_addr  = 1'b1;
                    ctl.alu_fn      = ALU_INC_B;
                    ctl.pc_ce       = 1'b1;
                    ctl.ir_ce       = 1'b1;
                    ctl.mem_req     = 1'b1;
                    phase_d         = PH_EXEC;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    input  word_t mem_rdata,
    output addr_t mem_addr,
    output word_t mem_wdata,
    output opc_t  opcode,
    output logic  acc_zero,
    output logic  acc_neg
);

    addr_t pc_q;
    word_t ir_q;
    word_t acc_q;
    word_t alu_b;
    word_t alu_y;
    addr_t addr_mux;

    assign addr_mux = ctl.addr_sel_op ? ir_q[ADDR_W-1:0] : pc_q;
    assign alu_b    = ctl.b_sel_addr ? zext_addr(addr_mux) : mem_rdata;
    assign alu_y    = alu_eval(ctl.alu_fn, acc_q, alu_b);

    acc_en_reg #(.W(ADDR_W)) u_pc (
        .clk (clk),
        .rst (rst),
        .en  (ctl.pc_ce),
        .d   (alu_y[ADDR_W-1:0]),
        .q   (pc_q)
    );

    acc_en_reg #(.W(WORD_W)) u_ir (
        .clk (clk),
        .rst (rst),
        .en  (ctl.ir_ce),
        .d   (mem_rdata),
        .q   (ir_q)
    );

    acc_en_reg #(.W(WORD_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .en  (ctl.acc_ce),
        .d   (alu_y),
        .q   (acc_q)
    );

    assign mem_addr  = addr_mux;
    assign mem_wdata = ctl.acc_oe ? acc_q : '0;
    assign opcode    = ir_q[WORD_W-1:ADDR_W];
    assign acc_zero  = (acc_q == '0);
    assign acc_neg   = acc_q[WORD_W-1];

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_rnw,
    output logic              halted
);

    ctrl_t ctl;
    opc_t  opcode;
    logic  acc_zero;
    logic  acc_neg;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .ctl      (ctl),
        .halted   (halted)
    );

    acc_cpu_dpath u_dpath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg)
    );

    assign mem_req = ctl.mem_req;
    assign mem_rnw = ctl.mem_rnw;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_req,
    input logic              mem_rnw,
    input logic              halted
);

    // R3: write data bus idles at zero whenever no write is made
    a_r3_wdata_idle: assert property (@(posedge clk) disable iff (rst)
        mem_rnw |-> (mem_wdata == '0));

    // R5: a store occupies a single cycle and is followed by a read fetch
    a_r5_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
        !mem_rnw |=> (mem_rnw && mem_req));

    // R6: first cycle out of reset fetches word 0
    a_r6_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_addr == '0 && mem_req && mem_rnw));

    // R7: halt persists until reset
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R7: no memory traffic while halted
    a_r7_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);

    // R9: a running core always requests memory
    a_r9_req_running: assert property (@(posedge clk) disable iff (rst)
        !halted |-> mem_req);

endmodule

bind acc_cpu_core acc_cpu_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_req   (mem_req),
    .mem_rnw   (mem_rnw),
    .halted    (halted)
);

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/100ps
module sim_acc_cpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_req;
    logic        mem_rnw;
    logic        halted;

    logic [15:0] mem [0:4095];

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    acc_cpu_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_rnw   (mem_rnw),
        .halted    (halted)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && !mem_rnw) mem[mem_addr] <= mem_wdata;
    end

    // {init acc, operand word, opcode, expected word at 0x032, expected edges}
    localparam int NV = 15;
    localparam logic [59:0] VECS [NV] = '{
        {16'h1234, 16'hABCD, 4'h0, 16'hABCD, 8'd7},
        {16'h1234, 16'h0F0F, 4'h2, 16'h2143, 8'd7},
        {16'hFFFF, 16'h0002, 4'h2, 16'h0001, 8'd7},
        {16'h0005, 16'h0007, 4'h3, 16'hFFFE, 8'd7},
        {16'h8000, 16'h0001, 4'h3, 16'h7FFF, 8'd7},
        {16'h4321, 16'h0000, 4'h1, 16'h4321, 8'd7},
        {16'h0000, 16'h0000, 4'h4, 16'hBEEF, 8'd8},
        {16'h0000, 16'h0000, 4'h5, 16'hBEEF, 8'd8},
        {16'h7FFF, 16'h0000, 4'h5, 16'hBEEF, 8'd8},
        {16'h8000, 16'h0000, 4'h5, 16'h8000, 8'd6},
        {16'h0000, 16'h0000, 4'h6, 16'h0000, 8'd6},
        {16'hFFFF, 16'h0000, 4'h6, 16'hBEEF, 8'd8},
        {16'h1111, 16'h2222, 4'h7, 16'h5555, 8'd3},
        {16'h1111, 16'h2222, 4'hC, 16'h5555, 8'd3},
        {16'h1111, 16'h2222, 4'hF, 16'h5555, 8'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic release_reset();
        rst = 1'b0;
        #0.5;
    endtask

    // Counts rising edges from reset release until halted is seen.
    task automatic run_to_halt(output int edges);
        edges = 0;
        while (!halted && edges < 200) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    function automatic string op_req(input logic [3:0] op);
        case (op)
            4'h0:          return "R1";
            4'h1:          return "R3";
            4'h2, 4'h3:    return "R2";
            4'h4, 4'h5,
            4'h6:          return "R4";
            default:       return "R7";
        endcase
    endfunction

    initial begin
        int edges;

        // ---------------- reset state (R6)
        hold_reset();
        check("R6 no request in reset", {31'd0, mem_req}, 32'd0);
        check("R6 not halted in reset", {31'd0, halted}, 32'd0);
        mem[0] = 16'h7000;
        release_reset();
        check("R6 first fetch address", {20'd0, mem_addr}, 32'h000);
        check("R9 request after reset", {30'd0, mem_req, mem_rnw}, 32'd3);

        // ---------------- vector table
        for (int v = 0; v < NV; v++) begin
            logic [15:0] init_acc, opnd, expw;
            logic [3:0]  op;
            logic [7:0]  expc;
            logic [11:0] s;
            {init_acc, opnd, op, expw, expc} = VECS[v];
            s = (op >= 4'h4 && op <= 4'h6) ? 12'h008 : 12'h031;
            hold_reset();
            mem[12'h000] = 16'h0030;
            mem[12'h001] = {op, s};
            mem[12'h002] = 16'h1032;
            mem[12'h003] = 16'h7000;
            mem[12'h008] = 16'h0033;
            mem[12'h009] = 16'h1032;
            mem[12'h00A] = 16'h7000;
            mem[12'h030] = init_acc;
            mem[12'h031] = opnd;
            mem[12'h032] = 16'h5555;
            mem[12'h033] = 16'hBEEF;
            release_reset();
            run_to_halt(edges);
            check(op_req(op), {16'd0, mem[12'h032]}, {16'd0, expw});
            check("R5 cycle count", edges, {24'd0, expc});
            if (op == 4'h1) check("R3 stored at S", {16'd0, mem[12'h031]}, {16'd0, init_acc});
            if (op >= 4'h7) check("R7 halt quiet", {31'd0, mem_req}, 32'd0);
        end

        // ---------------- countdown loop program
        hold_reset();
        mem[12'h000] = 16'h0020;   // load
        mem[12'h001] = 16'h3021;   // subtract
        mem[12'h002] = 16'h1020;   // store
        mem[12'h003] = 16'h6001;   // jump if non-zero
        mem[12'h004] = 16'h7000;   // stop
        mem[12'h020] = 16'h0003;
        mem[12'h021] = 16'h0001;
        release_reset();
        edges = 0;
        while (!halted && edges < 200) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 1) begin
                check("R1 operand address", {20'd0, mem_addr}, 32'h020);
                check("R3 no write data on load", {16'd0, mem_wdata}, 32'h0);
            end
            if (edges == 5) begin
                check("R3 store strobe", {31'd0, mem_rnw}, 32'd0);
                check("R3 store data", {16'd0, mem_wdata}, 32'h0002);
                check("R3 store address", {20'd0, mem_addr}, 32'h020);
            end
            if (edges == 7) check("R4 jump target fetch", {20'd0, mem_addr}, 32'h001);
        end
        check("R5 loop cycle count", edges, 32'd18);
        check("R4 loop final value", {16'd0, mem[12'h020]}, 32'h0);
        check("R7 halted raised", {31'd0, halted}, 32'd1);
        repeat (3) @(negedge clk);
        check("R7 halt sticky", {30'd0, halted, mem_req}, 32'd2);
        check("R7 memory untouched after halt", {16'd0, mem[12'h020]}, 32'h0);

        // ---------------- program counter wrap (R8)
        hold_reset();
        mem[12'h000] = 16'h4FFF;
        mem[12'hFFF] = 16'h1050;
        release_reset();
        @(posedge clk); @(negedge clk);
        check("R8 jump to top word", {20'd0, mem_addr}, 32'hFFF);
        @(posedge clk); @(negedge clk);
        check("R3 store from top word", {19'd0, mem_addr, mem_rnw}, {19'd0, 12'h050, 1'b0});
        @(posedge clk); @(negedge clk);
        check("R8 wrapped fetch address", {20'd0, mem_addr}, 32'h000);

        hold_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule